// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit RISC core and chooses the next one. Each cycle it sees the current instruction word and the two register operand values read for it. When the step strobe is high, the next clock edge loads the PC with the address of the following instruction. That address is one of: the sequential successor, a PC-relative branch target, a region-local absolute jump target, or a 32-bit address taken from a register.

For the call form of the jump, the unit also presents a return address with a register index and a write strobe, which go straight to the register file's write port. A jump through a register to an address that is not word aligned is still taken. A flag records that it happened, so that surrounding logic can act on it.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `pc_q` equals the parameter `START_ADDR` (default 0x0000_0000) and `jr_misalign` is 0; `link_we` is 0 while `step` is 0.
- R2: On a clock edge with `step` low, `pc_q` and `jr_misalign` keep their values.
- R3: A stepped instruction that is not one of the control-flow encodings below advances `pc_q` by 4. This includes opcode 0 (bits 31:26) with any function code (bits 5:0) other than 0x08.
- R4: Opcode 0x04: when `rs_val` equals `rt_val`, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2; otherwise it is PC+4. Negative offsets move backwards.
- R5: Opcode 0x05: the same target arithmetic as R4, taken when `rs_val` differs from `rt_val`; otherwise PC+4.
- R6: Opcode 0x02: the next PC is {(PC+4)[31:28], instr[25:0], 2'b00}.
- R7: Opcode 0x03: the next PC is as in R6. In the same cycle, while `step` is high, `link_we` is 1, `link_idx` is 31 and `link_val` is PC+4.
- R8: Opcode 0 with function code 0x08: the next PC is `rs_val` unchanged, including its two low bits.
- R9: After a stepped R8 jump whose `rs_val[1:0]` is nonzero, `jr_misalign` is 1. Any other stepped instruction clears it.
- R10: `link_we` is 0 in every cycle except a stepped opcode 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | Advance the PC on this clock edge |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc_q | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write strobe |
| link_idx | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address, PC+4 |
| jr_misalign | output | 1 | Last stepped instruction jumped to an unaligned register address |

## Verification
The link outputs are combinational from the instruction and the step strobe. The bench therefore checks them one time unit after it drives the inputs, before the clock edge that consumes them. The new PC and the misalignment flag pass through one register, so they are checked one time unit after the edge that follows the stepped cycle. At that point the bench also advances its own PC model. Reset is checked after the internal two-stage release has finished, and the bench holds `step` low through that window.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_JUMP    = 6'h02;
  localparam logic [5:0] OPC_CALL    = 6'h03;
  localparam logic [5:0] OPC_BR_EQ   = 6'h04;
  localparam logic [5:0] OPC_BR_NE   = 6'h05;
  localparam logic [5:0] FN_JREG     = 6'h08;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_JABS = 2'd2,
    FLOW_JREG = 2'd3
  } flow_e;

  typedef struct packed {
    flow_e flow;
    logic  br_on_ne;
    logic  link;
  } pcs_dec_t;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [31:0] instr,
  output pcs_dec_t    dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec.flow     = FLOW_SEQ;
    dec.br_on_ne = 1'b0;
    dec.link     = 1'b0;
    unique case (opc)
      OPC_BR_EQ: dec.flow = FLOW_BR;
      OPC_BR_NE: begin
        dec.flow     = FLOW_BR;
        dec.br_on_ne = 1'b1;
      end
      OPC_JUMP:  dec.flow = FLOW_JABS;
      OPC_CALL: begin
        dec.flow = FLOW_JABS;
        dec.link = 1'b1;
      end
      OPC_SPECIAL: begin
        if (fn == FN_JREG) dec.flow = FLOW_JREG;
      end
      default: dec.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int JIDX_W   = 26,
  parameter int ALIGN_SH = 2
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  pcs_dec_t        dec,
  output logic [XLEN-1:0] pc_seq,
  output logic [XLEN-1:0] pc_tgt,
  output logic            tgt_unaligned
);
  localparam int REGION_W = XLEN - JIDX_W - ALIGN_SH;
  localparam int SEXT_W   = XLEN - IMM_W - ALIGN_SH;
  localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(1 << ALIGN_SH);

  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] abs_tgt;
  logic            ops_equal;
  logic            br_taken;

  assign pc_seq    = pc_cur + STEP_BYTES;
  assign br_disp   = {{SEXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], {ALIGN_SH{1'b0}}};
  assign br_tgt    = pc_seq + br_disp;
  assign abs_tgt   = {pc_seq[XLEN-1 -: REGION_W], instr[JIDX_W-1:0], {ALIGN_SH{1'b0}}};
  assign ops_equal = (rs_val == rt_val);
  assign br_taken  = dec.br_on_ne ? !ops_equal : ops_equal;

  always_comb begin
    tgt_unaligned = 1'b0;
    unique case (dec.flow)
      FLOW_BR:   pc_tgt = br_taken ? br_tgt : pc_seq;
      FLOW_JABS: pc_tgt = abs_tgt;
      FLOW_JREG: begin
        pc_tgt        = rs_val;
        tgt_unaligned = |rs_val[ALIGN_SH-1:0];
      end
      default:   pc_tgt = pc_seq;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] START_ADDR = 32'h0000_0000,
  parameter int          LINK_REG   = 31,
  parameter int          RIDX_W     = 5,
  parameter int          RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   pc_q,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              jr_misalign
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;
  pcs_dec_t              dec;
  logic [XLEN-1:0]       pc_seq;
  logic [XLEN-1:0]       pc_tgt;
  logic                  tgt_unaligned;
  logic [XLEN-1:0]       pc_d;
  logic                  mis_d;

  // Reset asserts at once and releases after RST_STAGES edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  pcs_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  pcs_target #(.XLEN(XLEN)) u_target (
    .pc_cur        (pc_q),
    .instr         (instr),
    .rs_val        (rs_val),
    .rt_val        (rt_val),
    .dec           (dec),
    .pc_seq        (pc_seq),
    .pc_tgt        (pc_tgt),
    .tgt_unaligned (tgt_unaligned)
  );

  // Next-state selection, enabled by step.
  always_comb begin
    pc_d  = pc_q;
    mis_d = jr_misalign;
    if (step) begin
      pc_d  = pc_tgt;
      mis_d = tgt_unaligned;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q        <= START_ADDR;
      jr_misalign <= 1'b0;
    end else begin
      pc_q        <= pc_d;
      jr_misalign <= mis_d;
    end
  end

  assign link_we  = step && dec.link;
  assign link_idx = RIDX_W'(LINK_REG);
  assign link_val = pc_seq;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc_q,
  input logic        link_we,
  input logic [4:0]  link_idx,
  input logic [31:0] link_val,
  input logic        jr_misalign
);
  logic [5:0]  c_op;
  logic        c_jr;
  logic [31:0] c_disp;

  assign c_op   = instr[31:26];
  assign c_jr   = (c_op == 6'h00) && (instr[5:0] == 6'h08);
  assign c_disp = {{14{instr[15]}}, instr[15:0], 2'b00};

  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && c_op != 6'h02 && c_op != 6'h03 && c_op != 6'h04 && c_op != 6'h05 && !c_jr)
    |=> pc_q == $past(pc_q) + 32'd4);

  a_r4_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (step && c_op == 6'h04 && rs_val == rt_val)
    |=> pc_q == $past(pc_q) + 32'd4 + $past(c_disp));

  a_r7_link_only_call: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (step && c_op == 6'h03 && link_idx == 5'd31 && link_val == pc_q + 32'd4));

  a_r8_jreg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step && c_jr) |=> pc_q == $past(rs_val));

  a_r9_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> jr_misalign == ($past(c_jr) && ($past(rs_val[1:0]) != 2'b00)));
endmodule

bind pc_sequencer pcs_checker u_chk (.*);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk;
  logic        rst_n;
  logic        step;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc_q;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        jr_misalign;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] m_pc;
  logic        m_mis;
  bit          done = 0;

  pc_sequencer u_pc_sequencer (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_next(input logic [31:0] pc, input logic [31:0] ins,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] p4;
    logic [31:0] disp;
    p4   = pc + 32'd4;
    disp = {{14{ins[15]}}, ins[15:0], 2'b00};
    case (ins[31:26])
      6'h04:   return (a == b) ? p4 + disp : p4;
      6'h05:   return (a != b) ? p4 + disp : p4;
      6'h02,
      6'h03:   return {p4[31:28], ins[25:0], 2'b00};
      6'h00:   return (ins[5:0] == 6'h08) ? a : p4;
      default: return p4;
    endcase
  endfunction

  task automatic do_cycle(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                          input logic stp, input string req);
    logic [31:0] e_pc;
    logic        e_we;
    logic        e_mis;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b; step = stp;
    #1;
    e_we = stp && (ins[31:26] == 6'h03);
    chk({req, " R10 link_we"}, 32'(link_we), 32'(e_we));
    if (e_we) begin
      chk("R7 link_idx", 32'(link_idx), 32'd31);
      chk("R7 link_val", link_val, m_pc + 32'd4);
    end
    e_pc  = stp ? mk_next(m_pc, ins, a, b) : m_pc;
    e_mis = stp ? (ins[31:26] == 6'h00 && ins[5:0] == 6'h08 && a[1:0] != 2'b00) : m_mis;
    @(posedge clk);
    #1;
    chk({req, " pc"}, pc_q, e_pc);
    chk({req, " R9 misalign"}, 32'(jr_misalign), 32'(e_mis));
    m_pc  = e_pc;
    m_mis = e_mis;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] ins, a, b;
    void'($urandom(32'd20240611));
    rst_n = 0; step = 0; instr = 0; rs_val = 0; rt_val = 0;
    m_pc = 32'h0; m_mis = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_q, 32'h0);
    chk("R1 misalign", 32'(jr_misalign), 32'd0);
    chk("R1 link_we", 32'(link_we), 32'd0);
    // R2 hold with a call instruction present but no step
    do_cycle({6'h03, 26'h3FF_FFFF}, 0, 0, 1'b0, "R2 hold");
    do_cycle(32'h2002_0005, 0, 0, 1'b1, "R3 seq");
    do_cycle({6'h00, 20'h0, 6'h20}, 32'h40, 0, 1'b1, "R3 special non-jr");
    do_cycle({6'h04, 10'h0, 16'h0010}, 32'h7, 32'h7, 1'b1, "R4 beq taken");
    do_cycle({6'h04, 10'h0, 16'h0010}, 32'h7, 32'h8, 1'b1, "R4 beq not taken");
    do_cycle({6'h05, 10'h0, 16'hFFF0}, 32'h1, 32'h2, 1'b1, "R5 bne taken backward");
    do_cycle({6'h05, 10'h0, 16'h0100}, 32'h5, 32'h5, 1'b1, "R5 bne not taken");
    do_cycle({6'h00, 5'd9, 15'h0, 6'h08}, 32'hA000_0100, 0, 1'b1, "R8 jr aligned");
    do_cycle({6'h02, 26'h012_3456}, 0, 0, 1'b1, "R6 jump keeps region");
    do_cycle({6'h03, 26'h000_0040}, 0, 0, 1'b1, "R7 call");
    do_cycle({6'h00, 5'd3, 15'h0, 6'h08}, 32'h0000_2002, 0, 1'b1, "R9 jr misaligned");
    do_cycle(32'h0, 0, 0, 1'b0, "R2 flag held");
    do_cycle(32'h0, 0, 0, 1'b1, "R9 flag cleared");
    do_cycle({6'h04, 10'h0, 16'h8000}, 32'h3, 32'h3, 1'b1, "R4 most negative offset");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 6));
      ins  = $urandom();
      case (pick)
        3'd0: ins[31:26] = 6'h04;
        3'd1: ins[31:26] = 6'h05;
        3'd2: ins[31:26] = 6'h02;
        3'd3: ins[31:26] = 6'h03;
        3'd4: begin ins[31:26] = 6'h00; ins[5:0] = 6'h08; end
        3'd5: ins[31:26] = 6'h00;
        default: ;
      endcase
      a = $urandom();
      if ($urandom_range(0, 1) == 0) a[1:0] = 2'b00;
      b = ($urandom_range(0, 1) == 0) ? a : $urandom();
      do_cycle(ins, a, b, ($urandom_range(0, 3) != 0), "R3-mix random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule